// File: doc/BRIEF.md
# Commit Trace Buffer with Shadow Registers

This debug block sits beside a dual-issue core and records the history of retired instructions. In every cycle where at least one of the two commit slots retires an instruction, it stores a single entry. The entry holds, for each slot, the program counter, a valid bit, a small field of event flags (mispredict, exception and similar), the destination register index, a write-enable and the result data. Entries go into a ring whose depth is a build-time parameter. When the ring is full, each new commit replaces the oldest entry.

Next to the ring the block keeps a shadow copy of the 32 architectural registers. This copy describes the register state just before the oldest entry still held. It is maintained by replaying the register writes of each entry into the copy at the moment that entry is evicted. A debugger can therefore take the shadow copy as a base and replay the stored entries forward to rebuild the register state at any retained point.

Capture can be stopped in two ways. A breakpoint-style input stops it in the same cycle, and a control bit written over the memory-mapped port also stops it. Software clears that bit to resume. Reads over the same port return the control bit, a status word, any shadow register or any word of any entry.

Top module: `commit_trace_buffer`

## Requirements
- R1: After reset the control freeze bit reads 0, the status word reads 0 (write pointer 0, not wrapped), and all 32 shadow registers read 0.
- R2: A cycle in which cm_vld is nonzero and capture is not frozen stores both slots into the entry at the write pointer, and the pointer then advances by one modulo DEPTH. Each slot stores its pc, valid bit, write-enable, destination index, flags and data, whether that slot is valid or not. A cycle with cm_vld equal to 0 stores nothing and leaves the pointer unchanged.
- R3: When a capture takes the pointer from DEPTH-1 back to 0, the wrapped flag (status bit 31) becomes 1 and stays 1 until reset.
- R4: The shadow registers do not change while the wrapped flag is 0. Once wrapped, each capture first applies the register writes of the entry it replaces to the shadow registers, and only then overwrites that entry.
- R5: When both slots of a replaced entry write the same register, the shadow register ends with the slot 1 data.
- R6: A stored slot changes the shadow registers only if its valid bit and write-enable are both 1 and its destination index is nonzero. Shadow register 0 always reads 0.
- R7: freeze_in high blocks capture in that same cycle and sets the control freeze bit from the next cycle on. While the bit is 1, no capture and no shadow update take place. Writing 1 to control bit 0 also freezes capture. Writing 0 resumes capture, unless freeze_in is high in that cycle, in which case freeze_in wins.
- R8: Register map (word addresses, region = the top two address bits). Region 00: address bit 0 = 0 is control (bit 0 = freeze), address bit 0 = 1 is status (bits [IW-1:0] = write pointer, bit 31 = wrapped). Region 01: shadow register addr[4:0]. Region 10: entry addr[IW+2:3], word addr[2:0], where the words are 0 = slot 0 pc, 1 = slot 0 info, 2 = slot 0 data, 3 = slot 1 pc, 4 = slot 1 info, 5 = slot 1 data, and 6/7 read 0. An info word holds bit 0 = valid, bit 1 = write-enable, bits [6:2] = destination, and bits [6+FLAG_W:7] = flags. Region 11 reads 0. Read data appears on bus_rdata one clock after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_vld | input | 2 | Per-slot commit valid (bit 0 = slot 0) |
| cm_pc0 | input | XLEN | Slot 0 program counter |
| cm_pc1 | input | XLEN | Slot 1 program counter |
| cm_flags0 | input | FLAG_W | Slot 0 event flags |
| cm_flags1 | input | FLAG_W | Slot 1 event flags |
| cm_rd0 | input | 5 | Slot 0 destination register |
| cm_rd1 | input | 5 | Slot 1 destination register |
| cm_we0 | input | 1 | Slot 0 writes its destination |
| cm_we1 | input | 1 | Slot 1 writes its destination |
| cm_data0 | input | XLEN | Slot 0 result data |
| cm_data1 | input | XLEN | Slot 1 result data |
| freeze_in | input | 1 | Stop capture now (for example on a breakpoint hit) |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IW+5 | Word address |
| bus_wbit | input | 1 | Write value for the control freeze bit |
| bus_rdata | output | XLEN | Read data, one clock after the request |

## Verification
The ring is filled with commit cycles of several kinds: both slots valid, only slot 0 valid, and only slot 1 valid, separated by idle cycles that must leave no trace. This separates per-slot storage from per-cycle gating. The eviction pass replays entries that write one register from both slots, entries that write register 0, and entries whose write is disabled or whose slot is invalid. The resulting shadow contents show whether the evicted entry, rather than the incoming one, is applied, and in which slot order. Freeze is exercised with freeze_in coinciding with a commit, with software setting and clearing the bit, and with commits arriving while frozen, all after wrap so that stray shadow updates would also show.

// File: rtl/commit_trace_buffer.sv
module commit_trace_buffer #(
  parameter  int DEPTH  = 64,
  parameter  int XLEN   = 32,
  parameter  int FLAG_W = 4,
  localparam int IW     = $clog2(DEPTH),
  localparam int AW     = IW + 5,
  localparam int IFW    = 7 + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cm_vld,
  input  logic [XLEN-1:0]   cm_pc0,
  input  logic [XLEN-1:0]   cm_pc1,
  input  logic [FLAG_W-1:0] cm_flags0,
  input  logic [FLAG_W-1:0] cm_flags1,
  input  logic [4:0]        cm_rd0,
  input  logic [4:0]        cm_rd1,
  input  logic              cm_we0,
  input  logic              cm_we1,
  input  logic [XLEN-1:0]   cm_data0,
  input  logic [XLEN-1:0]   cm_data1,
  input  logic              freeze_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wbit,
  output logic [XLEN-1:0]   bus_rdata
);

  logic            frz_q, wrap_q;
  logic [IW-1:0]   wp_q;
  logic [XLEN-1:0] shd [32];

  logic [XLEN-1:0] m_pc0 [DEPTH];
  logic [XLEN-1:0] m_pc1 [DEPTH];
  logic [XLEN-1:0] m_d0  [DEPTH];
  logic [XLEN-1:0] m_d1  [DEPTH];
  logic [IFW-1:0]  m_inf0 [DEPTH];
  logic [IFW-1:0]  m_inf1 [DEPTH];

  logic            cap, ev0, ev1, ctl_wr;
  logic [IW-1:0]   ei;
  logic [XLEN-1:0] rd_mux;

  assign cap    = (|cm_vld) && !frz_q && !freeze_in;
  assign ev0    = m_inf0[wp_q][0] && m_inf0[wp_q][1] && (m_inf0[wp_q][6:2] != 5'd0);
  assign ev1    = m_inf1[wp_q][0] && m_inf1[wp_q][1] && (m_inf1[wp_q][6:2] != 5'd0);
  assign ctl_wr = bus_sel && bus_wr && (bus_addr[AW-1:AW-2] == 2'b00) && !bus_addr[0];
  assign ei     = bus_addr[IW+2:3];

  always_ff @(posedge clk) begin
    if (cap) begin
      m_pc0[wp_q]  <= cm_pc0;
      m_pc1[wp_q]  <= cm_pc1;
      m_d0[wp_q]   <= cm_data0;
      m_d1[wp_q]   <= cm_data1;
      m_inf0[wp_q] <= {cm_flags0, cm_rd0, cm_we0, cm_vld[0]};
      m_inf1[wp_q] <= {cm_flags1, cm_rd1, cm_we1, cm_vld[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      wrap_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      if (cap) begin
        wp_q <= wp_q + 1'b1;
        if (wp_q == IW'(DEPTH - 1)) wrap_q <= 1'b1;
      end
      if (freeze_in)   frz_q <= 1'b1;
      else if (ctl_wr) frz_q <= bus_wbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) shd[i] <= '0;
    end else if (cap && wrap_q) begin
      if (ev0) shd[m_inf0[wp_q][6:2]] <= m_d0[wp_q];
      if (ev1) shd[m_inf1[wp_q][6:2]] <= m_d1[wp_q];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr[AW-1:AW-2])
      2'b00: begin
        if (bus_addr[0]) begin
          rd_mux[IW-1:0]  = wp_q;
          rd_mux[XLEN-1]  = wrap_q;
        end else begin
          rd_mux[0] = frz_q;
        end
      end
      2'b01: rd_mux = shd[bus_addr[4:0]];
      2'b10: begin
        case (bus_addr[2:0])
          3'd0:    rd_mux = m_pc0[ei];
          3'd1:    rd_mux = XLEN'(m_inf0[ei]);
          3'd2:    rd_mux = m_d0[ei];
          3'd3:    rd_mux = m_pc1[ei];
          3'd4:    rd_mux = XLEN'(m_inf1[ei]);
          3'd5:    rd_mux = m_d1[ei];
          default: rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cm_vld) && !frz_q && !freeze_in) |=> (wp_q == $past(wp_q) + 1'b1)) else $error("ptr step"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld == 2'b00) |=> $stable(wp_q)) else $error("idle hold"); // R2
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> wrap_q) else $error("wrap sticky"); // R3
  AST_FREEZE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_in |=> frz_q) else $error("freeze sets"); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q || freeze_in) |=> $stable(wp_q)) else $error("freeze hold"); // R7

  for (genvar g = 1; g < 32; g++) begin : g_shd_chk
    AST_SHD_PREWRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_q |=> $stable(shd[g])) else $error("shadow moved before wrap"); // R4
    AST_SHD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q || freeze_in) |=> $stable(shd[g])) else $error("shadow moved while frozen"); // R7
  end

endmodule

// File: tb/commit_trace_buffer_tb.sv
`timescale 1ns/1ps
module commit_trace_buffer_tb;
  localparam int D  = 8;
  localparam int AW = 8;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [1:0] cm_vld;
  logic [31:0] cm_pc0, cm_pc1, cm_data0, cm_data1;
  logic [3:0] cm_flags0, cm_flags1;
  logic [4:0] cm_rd0, cm_rd1;
  logic cm_we0, cm_we1, freeze_in;
  logic bus_sel, bus_wr, bus_wbit;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_rdata;

  commit_trace_buffer #(.DEPTH(D), .XLEN(32), .FLAG_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cm_vld(cm_vld),
    .cm_pc0(cm_pc0), .cm_pc1(cm_pc1), .cm_flags0(cm_flags0), .cm_flags1(cm_flags1),
    .cm_rd0(cm_rd0), .cm_rd1(cm_rd1), .cm_we0(cm_we0), .cm_we1(cm_we1),
    .cm_data0(cm_data0), .cm_data1(cm_data1), .freeze_in(freeze_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wbit(bus_wbit),
    .bus_rdata(bus_rdata));

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] xp0 [D], xp1 [D], xd0 [D], xd1 [D];
  logic [10:0] xi0 [D], xi1 [D];
  logic [31:0] xs [32];
  int xwp = 0;
  bit xwrap = 0, xfrz = 0;

  logic [31:0] qe [$];
  logic [7:0]  qa [$];
  string       qt [$];
  logic smp = 0;

  always @(posedge clk) smp <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (smp) begin
      logic [31:0] e; logic [7:0] a; string t;
      total++;
      if (qe.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty R8 act=%h exp=none", bus_rdata);
      end else begin
        e = qe.pop_front(); a = qa.pop_front(); t = qt.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s addr=%0h act=%h exp=%h", t, a, bus_rdata, e);
        end
      end
    end
  end

  function automatic logic [7:0] ea(int idx, int w);
    return 8'(128 + idx * 8 + w);
  endfunction

  function automatic logic [31:0] stat_exp();
    logic [31:0] s;
    s = 32'(xwp);
    s[31] = xwrap;
    return s;
  endfunction

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    qe.push_back(e); qa.push_back(a); qt.push_back(t);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr_ctl(input logic b);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h00; bus_wbit = b;
    if (!freeze_in) xfrz = b;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic cmt(input logic [1:0] v, input logic [31:0] p0, input logic [31:0] p1,
                     input logic [3:0] f0, input logic [3:0] f1,
                     input logic [4:0] r0, input logic [4:0] r1,
                     input logic w0, input logic w1,
                     input logic [31:0] d0, input logic [31:0] d1, input logic frz);
    cm_vld = v; cm_pc0 = p0; cm_pc1 = p1; cm_flags0 = f0; cm_flags1 = f1;
    cm_rd0 = r0; cm_rd1 = r1; cm_we0 = w0; cm_we1 = w1;
    cm_data0 = d0; cm_data1 = d1; freeze_in = frz;
    if (|v && !frz && !xfrz) begin
      if (xwrap) begin
        if (xi0[xwp][0] && xi0[xwp][1] && xi0[xwp][6:2] != 0) xs[xi0[xwp][6:2]] = xd0[xwp];
        if (xi1[xwp][0] && xi1[xwp][1] && xi1[xwp][6:2] != 0) xs[xi1[xwp][6:2]] = xd1[xwp];
      end
      xp0[xwp] = p0; xp1[xwp] = p1; xd0[xwp] = d0; xd1[xwp] = d1;
      xi0[xwp] = {f0, r0, w0, v[0]};
      xi1[xwp] = {f1, r1, w1, v[1]};
      if (xwp == D - 1) xwrap = 1;
      xwp = (xwp + 1) % D;
    end
    if (frz) xfrz = 1;
    @(negedge clk);
    cm_vld = 0; freeze_in = 0;
  endtask

  task automatic check_shadow();
    for (int r = 0; r < 32; r++) begin
      string tg;
      tg = (r == 7) ? "R5" : ((r == 0 || r == 9 || r == 10) ? "R6" : "R4");
      rd(8'(64 + r), xs[r], tg);
    end
  endtask

  task automatic check_entries();
    for (int i = 0; i < D; i++) begin
      if (xwrap || i < xwp) begin
        rd(ea(i, 0), xp0[i], "R2");
        rd(ea(i, 1), {21'b0, xi0[i]}, "R2");
        rd(ea(i, 2), xd0[i], "R2");
        rd(ea(i, 3), xp1[i], "R2");
        rd(ea(i, 4), {21'b0, xi1[i]}, "R2");
        rd(ea(i, 5), xd1[i], "R2");
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) xs[r] = 0;
    rst_n = 0; cm_vld = 0; cm_pc0 = 0; cm_pc1 = 0; cm_data0 = 0; cm_data1 = 0;
    cm_flags0 = 0; cm_flags1 = 0; cm_rd0 = 0; cm_rd1 = 0; cm_we0 = 0; cm_we1 = 0;
    freeze_in = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wbit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, 32'h0, "R1");
    rd(8'h01, 32'h0, "R1");
    for (int r = 0; r < 32; r++) rd(8'(64 + r), 32'h0, "R1");

    // R2 slot patterns with an idle cycle in between
    cmt(2'b11, 32'h100, 32'h104, 4'h1, 4'h2, 5'd3, 5'd4, 1, 1, 32'hAAAA0003, 32'hAAAA0004, 0);
    cmt(2'b00, 32'hDEAD, 32'hBEEF, 4'hF, 4'hF, 5'd1, 5'd1, 1, 1, 32'h1, 32'h2, 0);
    cmt(2'b01, 32'h108, 32'h0, 4'h4, 4'h0, 5'd5, 5'd6, 1, 0, 32'hBBBB0005, 32'h0, 0);
    cmt(2'b10, 32'h0, 32'h110, 4'h0, 4'h8, 5'd0, 5'd6, 0, 1, 32'h0, 32'hCCCC0006, 0);
    rd(8'h01, stat_exp(), "R2");
    check_entries();
    rd(ea(1, 6), 32'h0, "R8");
    rd(8'hC5, 32'h0, "R8");

    // fill the ring: same-destination pair, r0 write, disabled writes
    cmt(2'b11, 32'h200, 32'h204, 4'h3, 4'h5, 5'd7, 5'd7, 1, 1, 32'h77770001, 32'h77770002, 0);
    cmt(2'b11, 32'h208, 32'h20C, 4'h0, 4'h0, 5'd0, 5'd12, 1, 1, 32'h00000BAD, 32'h12121212, 0);
    cmt(2'b01, 32'h210, 32'h214, 4'h2, 4'h2, 5'd9, 5'd10, 0, 1, 32'h99999999, 32'h10101010, 0);
    for (int i = 3; i < 5; i++)
      cmt(2'b11, 32'(32'h300 + i * 8), 32'(32'h304 + i * 8), 4'(i), 4'(i + 1),
          5'(13 + i), 5'(20 + i), 1, 1, 32'(32'h5000 + i), 32'(32'h6000 + i), 0);
    rd(8'h01, stat_exp(), "R3");
    check_shadow();

    // R4 eviction pass over the whole ring
    for (int i = 0; i < D; i++)
      cmt(2'b11, 32'(32'h400 + i * 8), 32'(32'h404 + i * 8), 4'(i), 4'(15 - i),
          5'(11 + i), 5'(19 + i), 1, 1, 32'(32'hE000 + i), 32'(32'hF000 + i), 0);
    rd(8'h01, stat_exp(), "R3");
    check_shadow();
    check_entries();

    // R7 freeze behaviour
    cmt(2'b11, 32'h500, 32'h504, 4'h1, 4'h1, 5'd2, 5'd3, 1, 1, 32'h55, 32'h66, 1);
    rd(8'h00, 32'h1, "R7");
    rd(8'h01, stat_exp(), "R7");
    cmt(2'b11, 32'h508, 32'h50C, 4'h1, 4'h1, 5'd2, 5'd3, 1, 1, 32'h57, 32'h68, 0);
    rd(8'h01, stat_exp(), "R7");
    check_shadow();
    wr_ctl(0);
    rd(8'h00, 32'h0, "R7");
    cmt(2'b01, 32'h510, 32'h0, 4'h6, 4'h0, 5'd8, 5'd0, 1, 0, 32'h88888888, 32'h0, 0);
    rd(8'h01, stat_exp(), "R7");
    wr_ctl(1);
    rd(8'h00, 32'h1, "R7");
    cmt(2'b11, 32'h520, 32'h524, 4'h1, 4'h1, 5'd2, 5'd3, 1, 1, 32'h1, 32'h2, 0);
    rd(8'h01, stat_exp(), "R7");
    wr_ctl(0);
    cmt(2'b10, 32'h0, 32'h530, 4'h0, 4'h9, 5'd0, 5'd4, 0, 1, 32'h0, 32'h44444444, 0);
    rd(8'h01, stat_exp(), "R7");
    check_shadow();
    check_entries();

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule